// File: doc/BRIEF.md
# Host Controller Interrupt Status and Command Register Block

This block holds two registers of a host-controller-style peripheral: a command/status word and an interrupt status word. A host reaches both through a byte-wide command code. Bit 7 of the code selects the direction (1 writes, 0 reads) and bits 6:0 pick the register. The command/status word is at code 0x02 and the interrupt status word is at code 0x03. A read returns its data on `rd_data` one clock after the code is presented. A write takes effect at the clock edge that samples it.

Single-cycle event pulses from the rest of the controller set sticky bits in the interrupt status word. Software removes a bit by writing a 1 to it. One event line, the scheduling-overrun event, also advances a 2-bit wrapping count that is visible in the command/status word. A registered interrupt line combines the status bits with per-bit enables and a master enable.

Setting bit 0 of the command/status word requests a controller reset. The request wipes the status bits and the overrun count, and it blocks host accesses for a fixed number of cycles. The hardware then clears the bit by itself.

Top module: `hcr_regs_top`

## Requirements
- R1: After synchronous reset, `irq` and `reset_busy` are 0, and reads of codes 0x02 and 0x03 both return 0.
- R2: A 1 on `evt_pulse[i]` sets interrupt status bit i. A read of code 0x03 returns the status bits in `rd_data[NEVT-1:0]` and zeros above them.
- R3: A write with code 0x83 clears each status bit whose `wr_data` bit is 1 and leaves the others as they are. No write can set a status bit.
- R4: When an event and a write-one-clear hit the same bit in the same cycle, the bit stays set.
- R5: `irq` is registered. It is 1 in the cycle after some status bit is 1, its `int_en` bit is 1 and `master_int_en` is 1. It drops one cycle after any of these conditions goes away.
- R6: The overrun count occupies bits 17:16 of a code 0x02 read. It increments on every pulse of `evt_pulse[OVR_BIT]`, including pulses that arrive while status bit OVR_BIT is already set, and it wraps from 3 to 0.
- R7: A write with code 0x82 and `wr_data[0]`=1 raises `reset_busy` (command/status bit 0) in the next cycle. The bit stays high for exactly RST_CYCLES cycles and then clears by itself. A write with `wr_data[0]`=0 does not start a reset.
- R8: Starting a reset clears all status bits and the overrun count. Events in that same cycle are lost.
- R9: While `reset_busy` is 1, every read returns 0 and every write is ignored. Events still set status bits during this time.
- R10: Command/status bits 31:18 and 15:1 read as 0 and ignore writes. A read of any other code returns 0, and a write to any other code changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command code valid this cycle |
| cmd_code | input | 8 | Bit 7 write flag, bits 6:0 register select |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| evt_pulse | input | NEVT | Event pulses, one per status bit |
| int_en | input | NEVT | Per-bit interrupt enables |
| master_int_en | input | 1 | Master interrupt enable |
| reset_busy | output | 1 | Controller reset in progress (command/status bit 0) |
| irq | output | 1 | Registered interrupt request |

## Verification
A lost or stuck status bit is seen on the next 0x03 read. It is also seen on `irq` one cycle after the enables point at that bit. A count that skips, sticks or saturates changes bits 17:16 of the next 0x02 read after a single overrun pulse, so the bench reads the count after each of several pulses and across the wrap. A reset counter loaded with the wrong value changes how many cycles `reset_busy` stays high, and the bench counts that length exactly. Writes that leak through during the busy window show up in the first read after it ends.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
  localparam int unsigned SOC_LSB = 16;
  localparam int unsigned SOC_W   = 2;
  localparam logic [6:0] CODE_CMDSTAT = 7'h02;
  localparam logic [6:0] CODE_INTSTAT = 7'h03;

  typedef enum logic [1:0] {
    RD_NONE    = 2'd0,
    RD_CMDSTAT = 2'd1,
    RD_INTSTAT = 2'd2
  } rd_sel_e;
endpackage

// File: rtl/hcr_cmd_decode.sv
module hcr_cmd_decode
  import hcr_pkg::*;
(
  input  logic       cmd_valid,
  input  logic [7:0] cmd_code,
  input  logic       busy,
  output logic       rd_en,
  output rd_sel_e    rd_sel,
  output logic       wr_cmdstat,
  output logic       wr_intstat
);
  logic is_write;

  always_comb begin
    is_write   = cmd_code[7];
    rd_en      = cmd_valid && !is_write;
    rd_sel     = RD_NONE;
    wr_cmdstat = 1'b0;
    wr_intstat = 1'b0;
    // No access is decoded while a controller reset is running
    if (cmd_valid && !busy) begin
      unique case (cmd_code[6:0])
        CODE_CMDSTAT: begin
          if (is_write) wr_cmdstat = 1'b1;
          else          rd_sel     = RD_CMDSTAT;
        end
        CODE_INTSTAT: begin
          if (is_write) wr_intstat = 1'b1;
          else          rd_sel     = RD_INTSTAT;
        end
        default: rd_sel = RD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/hcr_sticky_bank.sv
module hcr_sticky_bank #(
  parameter int unsigned NEVT = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wipe,
  input  logic [NEVT-1:0] evt,
  input  logic            clr_en,
  input  logic [NEVT-1:0] clr_mask,
  output logic [NEVT-1:0] status
);
  generate
    for (genvar i = 0; i < NEVT; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst || wipe) begin
          status[i] <= 1'b0;
        end else begin
          // A set in the same cycle as a clear wins
          status[i] <= (status[i] && !(clr_en && clr_mask[i])) || evt[i];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/hcr_reset_seq.sv
module hcr_reset_seq #(
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int unsigned CNT_W = $clog2(RST_CYCLES + 1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (!busy) begin
      if (start) begin
        busy   <= 1'b1;
        remain <= CNT_W'(RST_CYCLES - 1);
      end
    end else if (remain == '0) begin
      busy <= 1'b0;
    end else begin
      remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/hcr_regs_top.sv
module hcr_regs_top
  import hcr_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned NEVT       = 7,
  parameter int unsigned OVR_BIT    = 0,
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NEVT-1:0]   evt_pulse,
  input  logic [NEVT-1:0]   int_en,
  input  logic              master_int_en,
  output logic              reset_busy,
  output logic              irq
);
  logic             rd_en;
  rd_sel_e          rd_sel;
  logic             wr_cmdstat;
  logic             wr_intstat;
  logic             start_rst;
  logic [NEVT-1:0]  status_q;
  logic [SOC_W-1:0] soc_q;
  logic [DATA_W-1:0] cmdstat_word;
  logic [DATA_W-1:0] intstat_word;
  logic             unused_wr_bits;

  assign unused_wr_bits = ^wr_data;

  hcr_cmd_decode u_dec (
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_code),
    .busy       (reset_busy),
    .rd_en      (rd_en),
    .rd_sel     (rd_sel),
    .wr_cmdstat (wr_cmdstat),
    .wr_intstat (wr_intstat)
  );

  assign start_rst = wr_cmdstat && wr_data[0];

  hcr_reset_seq #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk   (clk),
    .rst   (rst),
    .start (start_rst),
    .busy  (reset_busy)
  );

  hcr_sticky_bank #(.NEVT(NEVT)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wipe     (start_rst),
    .evt      (evt_pulse),
    .clr_en   (wr_intstat),
    .clr_mask (wr_data[NEVT-1:0]),
    .status   (status_q)
  );

  // Overrun count keeps advancing whether or not its status bit is set
  always_ff @(posedge clk) begin
    if (rst || start_rst) soc_q <= '0;
    else if (evt_pulse[OVR_BIT]) soc_q <= soc_q + 1'b1;
  end

  always_comb begin
    cmdstat_word = '0;
    cmdstat_word[SOC_LSB +: SOC_W] = soc_q;
    cmdstat_word[0] = reset_busy;
    intstat_word = '0;
    intstat_word[NEVT-1:0] = status_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      unique case (rd_sel)
        RD_CMDSTAT: rd_data <= cmdstat_word;
        RD_INTSTAT: rd_data <= intstat_word;
        default:    rd_data <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= master_int_en && |(status_q & int_en);
  end
endmodule

// File: rtl/hcr_regs_chk.sv
module hcr_regs_chk #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned NEVT       = 7,
  parameter int unsigned OVR_BIT    = 0,
  parameter int unsigned RST_CYCLES = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [7:0]        cmd_code,
  input logic [DATA_W-1:0] rd_data,
  input logic [NEVT-1:0]   evt_pulse,
  input logic [NEVT-1:0]   int_en,
  input logic              master_int_en,
  input logic              reset_busy,
  input logic              irq,
  input logic [NEVT-1:0]   status_q,
  input logic [1:0]        soc_q
);
  logic armed;
  int unsigned busy_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      busy_run <= 0;
    end else begin
      armed    <= 1'b1;
      busy_run <= reset_busy ? busy_run + 1 : 0;
    end
  end

  // R7: reset request lasts exactly RST_CYCLES cycles
  p_busy_len_r7: assert property (@(posedge clk) disable iff (rst || !armed)
    $fell(reset_busy) |-> busy_run == RST_CYCLES);

  // R3: a status bit only rises after its event
  p_no_sw_set_r3: assert property (@(posedge clk) disable iff (rst || !armed)
    ((status_q & ~$past(status_q) & ~$past(evt_pulse)) == '0));

  // R4: every event is recorded unless a reset start wiped it
  p_set_wins_r4: assert property (@(posedge clk) disable iff (rst || !armed)
    !$rose(reset_busy) |-> (($past(evt_pulse) & ~status_q) == '0));

  // R5: irq follows the enabled status one cycle later
  p_irq_r5: assert property (@(posedge clk) disable iff (rst || !armed)
    irq == ($past(master_int_en) && |($past(status_q) & $past(int_en))));

  // R6: overrun count steps by one per overrun event
  p_soc_step_r6: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(evt_pulse[OVR_BIT]) && !$rose(reset_busy)) |-> soc_q == 2'($past(soc_q) + 2'd1));

  // R9: reads during a reset return zero
  p_busy_rd_zero_r9: assert property (@(posedge clk) disable iff (rst || !armed)
    (reset_busy && cmd_valid && !cmd_code[7]) |=> rd_data == '0);
endmodule

bind hcr_regs_top hcr_regs_chk #(
  .DATA_W(DATA_W), .NEVT(NEVT), .OVR_BIT(OVR_BIT), .RST_CYCLES(RST_CYCLES)
) chk_i (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .rd_data(rd_data), .evt_pulse(evt_pulse), .int_en(int_en),
  .master_int_en(master_int_en), .reset_busy(reset_busy), .irq(irq),
  .status_q(status_q), .soc_q(soc_q)
);

// File: tb/hcr_regs_top_tb_top.sv
module hcr_regs_top_tb_top;
  localparam int DATA_W = 32;
  localparam int NEVT = 7;
  localparam int RST_CYCLES = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_code = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic [NEVT-1:0] evt_pulse = '0;
  logic [NEVT-1:0] int_en = '0;
  logic master_int_en = 1'b0;
  logic reset_busy;
  logic irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hcr_regs_top #(.DATA_W(DATA_W), .NEVT(NEVT), .OVR_BIT(0), .RST_CYCLES(RST_CYCLES)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .wr_data(wr_data), .rd_data(rd_data), .evt_pulse(evt_pulse),
    .int_en(int_en), .master_int_en(master_int_en),
    .reset_busy(reset_busy), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply_reset();
    rst = 1'b1; cmd_valid = 1'b0; evt_pulse = '0; int_en = '0; master_int_en = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic bus_wr(input logic [7:0] code, input logic [31:0] data);
    cmd_valid = 1'b1; cmd_code = code; wr_data = data;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] code, output logic [31:0] val);
    cmd_valid = 1'b1; cmd_code = code;
    @(negedge clk);
    cmd_valid = 1'b0;
    val = rd_data;
  endtask

  task automatic pulse(input logic [NEVT-1:0] m);
    evt_pulse = m;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic wait_idle();
    while (reset_busy) @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    apply_reset();
    chk(irq == 1'b0, "R1 irq", 32'(irq), 0);
    chk(reset_busy == 1'b0, "R1 busy", 32'(reset_busy), 0);
    bus_rd(8'h02, v); chk(v == 0, "R1 cmdstat", v, 0);
    bus_rd(8'h03, v); chk(v == 0, "R1 intstat", v, 0);
  endtask

  task automatic t_event_set();
    logic [31:0] v;
    apply_reset();
    pulse(7'h24);
    bus_rd(8'h03, v); chk(v == 32'h24, "R2 set", v, 32'h24);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    apply_reset();
    pulse(7'h26);
    bus_wr(8'h83, 32'h22);
    bus_rd(8'h03, v); chk(v == 32'h04, "R3 clear ones", v, 32'h04);
    bus_wr(8'h83, 32'h40);
    bus_rd(8'h03, v); chk(v == 32'h04, "R3 no set", v, 32'h04);
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    apply_reset();
    pulse(7'h02);
    evt_pulse = 7'h02; cmd_valid = 1'b1; cmd_code = 8'h83; wr_data = 32'h02;
    @(negedge clk);
    evt_pulse = '0; cmd_valid = 1'b0;
    bus_rd(8'h03, v); chk(v == 32'h02, "R4 set wins", v, 32'h02);
  endtask

  task automatic t_irq();
    apply_reset();
    int_en = 7'h02; master_int_en = 1'b1;
    pulse(7'h02);
    chk(irq == 1'b0, "R5 registered delay", 32'(irq), 0);
    @(negedge clk);
    chk(irq == 1'b1, "R5 assert", 32'(irq), 1);
    master_int_en = 1'b0;
    @(negedge clk);
    chk(irq == 1'b0, "R5 master off", 32'(irq), 0);
    master_int_en = 1'b1;
    @(negedge clk);
    int_en = 7'h04;
    @(negedge clk);
    chk(irq == 1'b0, "R5 enable off", 32'(irq), 0);
    int_en = 7'h02;
    @(negedge clk);
    bus_wr(8'h83, 32'h02);
    chk(irq == 1'b1, "R5 clear delay", 32'(irq), 1);
    @(negedge clk);
    chk(irq == 1'b0, "R5 clear drop", 32'(irq), 0);
  endtask

  task automatic t_soc();
    logic [31:0] v;
    apply_reset();
    repeat (3) pulse(7'h01);
    bus_rd(8'h02, v); chk(v == 32'h0003_0000, "R6 count three", v, 32'h0003_0000);
    pulse(7'h01);
    bus_rd(8'h02, v); chk(v == 32'h0, "R6 wrap", v, 32'h0);
    pulse(7'h01);
    bus_rd(8'h03, v); chk(v == 32'h01, "R6 status held", v, 32'h01);
    bus_rd(8'h02, v); chk(v == 32'h0001_0000, "R6 count while set", v, 32'h0001_0000);
  endtask

  task automatic t_hcr();
    logic [31:0] v;
    int n;
    apply_reset();
    bus_wr(8'h82, 32'h0);
    chk(reset_busy == 1'b0, "R7 zero no start", 32'(reset_busy), 0);
    bus_wr(8'h82, 32'h1);
    n = 0;
    while (reset_busy) begin n++; @(negedge clk); end
    chk(n == RST_CYCLES, "R7 busy length", 32'(n), 32'(RST_CYCLES));
    bus_rd(8'h02, v); chk(v == 0, "R7 self cleared", v, 0);
  endtask

  task automatic t_reset_clears();
    logic [31:0] v;
    apply_reset();
    pulse(7'h01); pulse(7'h01); pulse(7'h10);
    bus_wr(8'h82, 32'h1);
    wait_idle();
    bus_rd(8'h03, v); chk(v == 0, "R8 status wiped", v, 0);
    bus_rd(8'h02, v); chk(v == 0, "R8 count wiped", v, 0);
  endtask

  task automatic t_busy_block();
    logic [31:0] v;
    apply_reset();
    bus_wr(8'h82, 32'h1);
    pulse(7'h08);
    bus_rd(8'h03, v); chk(v == 0, "R9 read zero while busy", v, 0);
    bus_wr(8'h83, 32'h7F);
    wait_idle();
    bus_rd(8'h03, v); chk(v == 32'h08, "R9 write ignored", v, 32'h08);
  endtask

  task automatic t_unused();
    logic [31:0] v;
    apply_reset();
    pulse(7'h01);
    bus_wr(8'h82, 32'hFFFF_FFFE);
    chk(reset_busy == 1'b0, "R10 no start", 32'(reset_busy), 0);
    bus_rd(8'h02, v); chk(v == 32'h0001_0000, "R10 unused zero", v, 32'h0001_0000);
    bus_rd(8'h05, v); chk(v == 0, "R10 unknown read", v, 0);
    bus_wr(8'h85, 32'hFFFF_FFFF);
    bus_wr(8'h84, 32'hFFFF_FFFF);
    bus_rd(8'h03, v); chk(v == 32'h01, "R10 unknown write", v, 32'h01);
    bus_rd(8'h02, v); chk(v == 32'h0001_0000, "R10 unknown write cs", v, 32'h0001_0000);
  endtask

  initial begin
    @(negedge clk);
    t_reset_state();
    t_event_set();
    t_w1c();
    t_set_wins();
    t_irq();
    t_soc();
    t_hcr();
    t_reset_clears();
    t_busy_block();
    t_unused();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule